// File: doc/BRIEF.md
# Four-Level Virtual Address Translation Walker

This block turns a 48-bit virtual address into a 56-bit physical address by walking a four-level radix table kept in memory. A client hands over the virtual address, the kind of access (load, store or instruction fetch) and the physical page number of the top-level table. The walker then fetches one 64-bit table entry per level through a read port with a request/ready handshake and a response-valid strobe.

Each fetched entry is either rejected as malformed, followed down as a pointer to the next table, or accepted as a leaf. A leaf may sit at any level. A leaf above the bottom level maps a large page. In that case the low page-number bits of the result come from the virtual address rather than from the entry.

The walker handles one translation at a time. It finishes each one with a single-cycle completion strobe that carries either a physical address or a fault flag. Accessed and dirty bits are never written back. An entry that would need such an update causes a fault.

Top module: `vm_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: A request is taken when `req_valid` and `req_ready` are both high. From the next cycle, `req_ready` stays low until the `done` pulse, including the pulse cycle itself, and goes high again in the cycle after it. `done` lasts exactly one cycle.
- R3: The first read goes to root*4096 + va[47:39]*8. After a pointer entry, the read for level i goes to entry_ppn*4096 + va[12+9i +: 9]*8. There is one read per visited level, in order from level 3 down.
- R4: An entry with bit 0 (valid) clear ends the walk with a fault.
- R5: An entry with bit 2 (write) set and bit 1 (read) clear faults, whatever bit 3 (execute) is. An entry with any of bits 63:54 set also faults.
- R6: A valid entry with bits 1 and 3 both clear is a pointer. The walk descends using its page number, held in bits 53:10. A pointer found at level 0 faults.
- R7: `req_acc` is encoded as 0 = load, 1 = store, 2 = fetch, 3 = reserved. A load needs bit 1 in the leaf, a store needs bit 2 and a fetch needs bit 3; a leaf without the needed bit faults. Code 3 always faults at a leaf.
- R8: A leaf with bit 6 (accessed) clear faults. A store to a leaf with bit 7 (dirty) clear faults.
- R9: A leaf at level i > 0 faults if any of the low 9*i bits of its page number are non-zero.
- R10: On success, `done_paddr` = {leaf page number, va[11:0]}. For a leaf at level i, page-number bits [9i-1:0] are replaced by va[12+9i-1:12].
- R11: On a fault, `done_fault` is 1 and `done_paddr` is 0.
- R12: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`. No new read is issued while a response is outstanding, and no read is issued while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 48 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| req_root | input | 44 | Page number of the top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Table entry |
| done | output | 1 | One-cycle completion strobe |
| done_fault | output | 1 | Translation failed |
| done_paddr | output | 56 | Translated physical address, 0 on fault |

## Verification
The bench targets leaves at every level. A wrong splice would show up as virtual page bits missing from a large-page result, or entry bits leaking into it. The bench also sets a single low page-number bit in an upper-level leaf; a walker that skips the alignment test would translate it instead of faulting. It covers the write-without-read encodings, a pointer sitting at the last level, and accessed/dirty combinations under store and load. A walker that mis-decodes any of these would return an address where a fault is due, or run off the bottom of the table. Random memory latency and ready gaps check that the read address stays put. They also check that exactly one read per visited level is made, at the address the table layout dictates.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } walk_st_e;

  localparam int BIT_V   = 0;
  localparam int BIT_R   = 1;
  localparam int BIT_W   = 2;
  localparam int BIT_X   = 3;
  localparam int BIT_A   = 6;
  localparam int BIT_D   = 7;
  localparam int PPN_LSB = 10;

  typedef struct packed {
    logic v;
    logic r;
    logic w;
    logic x;
    logic a;
    logic d;
  } pte_flags_t;

endpackage

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int VPN_W  = 9,
  parameter int PPN_W  = 44,
  parameter int RSVD_W = 10,
  parameter int LVL_W  = 2
) (
  input  pte_flags_t        flags,
  input  logic [RSVD_W-1:0] rsvd,
  input  logic [PPN_W-1:0]  ppn,
  input  logic [LVL_W-1:0]  lvl,
  input  acc_e              acc,
  output logic              bad_enc,
  output logic              is_leaf,
  output logic              perm_ok,
  output logic              ad_ok,
  output logic              sp_aligned,
  output logic              dead_end
);

  // permission bit demanded by an access kind; the reserved kind never passes
  function automatic logic grant(pte_flags_t f, acc_e a);
    case (a)
      ACC_LOAD:  grant = f.r;
      ACC_STORE: grant = f.w;
      ACC_EXEC:  grant = f.x;
      default:   grant = 1'b0;
    endcase
  endfunction

  // page-number bits that a leaf at this level must leave zero
  function automatic logic [PPN_W-1:0] below_mask(logic [LVL_W-1:0] l);
    below_mask = ~({PPN_W{1'b1}} << (VPN_W * int'(l)));
  endfunction

  assign bad_enc    = !flags.v || (flags.w && !flags.r) || (|rsvd);
  assign is_leaf    = flags.r || flags.x;
  assign perm_ok    = grant(flags, acc);
  assign ad_ok      = flags.a && ((acc != ACC_STORE) || flags.d);
  assign sp_aligned = (ppn & below_mask(lvl)) == '0;
  assign dead_end   = !is_leaf && (lvl == '0);

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W    = 48,
  parameter int PPN_W   = 44,
  parameter int VPN_W   = 9,
  parameter int PGOFF_W = 12,
  parameter int PTE_LG  = 3,
  parameter int LVL_W   = 2,
  parameter int PA_W    = 56
) (
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [PPN_W-1:0] leaf_ppn,
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  pte_addr,
  output logic [PA_W-1:0]  leaf_pa
);

  localparam int VPN_ALL = VA_W - PGOFF_W;

  function automatic logic [VPN_W-1:0] vpn_at(logic [VA_W-1:0] v, logic [LVL_W-1:0] l);
    logic [VPN_ALL-1:0] t;
    t = v[VA_W-1:PGOFF_W] >> (VPN_W * int'(l));
    vpn_at = t[VPN_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] entry_addr(logic [PPN_W-1:0] b, logic [VPN_W-1:0] idx);
    logic [PA_W-1:0] base_b;
    logic [PA_W-1:0] off;
    base_b = '0;
    base_b[PA_W-1:PGOFF_W] = b;
    off = '0;
    off[PTE_LG +: VPN_W] = idx;
    entry_addr = base_b + off;
  endfunction

  function automatic logic [PA_W-1:0] splice(logic [PPN_W-1:0] p, logic [VA_W-1:0] v,
                                             logic [LVL_W-1:0] l);
    logic [PPN_W-1:0] keep;
    logic [PPN_W-1:0] vp;
    keep = {PPN_W{1'b1}} << (VPN_W * int'(l));
    vp = '0;
    vp[VPN_ALL-1:0] = v[VA_W-1:PGOFF_W];
    splice = {(p & keep) | (vp & ~keep), v[PGOFF_W-1:0]};
  endfunction

  assign pte_addr = entry_addr(base_ppn, vpn_at(va, lvl));
  assign leaf_pa  = splice(leaf_ppn, va, lvl);

endmodule

// File: rtl/vm_walker.sv
module vm_walker
  import ptw_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PPN_W   = 44,
  parameter int LEVELS  = 4,
  parameter int VPN_W   = 9,
  parameter int PGOFF_W = 12,
  parameter int PTE_W   = 64,
  parameter int PTE_LG  = 3,
  localparam int PA_W   = PPN_W + PGOFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic [PPN_W-1:0] req_root,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             done_fault,
  output logic [PA_W-1:0]  done_paddr
);

  localparam int LVL_W  = $clog2(LEVELS);
  localparam int RSVD_W = PTE_W - PPN_LSB - PPN_W;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  walk_st_e         st;
  logic [LVL_W-1:0] lvl;
  logic [PPN_W-1:0] base_ppn;
  logic [VA_W-1:0]  va_q;
  acc_e             acc_q;
  logic             fault_q;
  logic [PA_W-1:0]  pa_q;

  pte_flags_t        flg;
  logic [PPN_W-1:0]  pte_ppn;
  logic [RSVD_W-1:0] pte_rsvd;
  logic bad_enc, is_leaf, perm_ok, ad_ok, sp_aligned, dead_end;
  logic [PA_W-1:0] leaf_pa;

  // named events, visible to the bound checker
  logic req_fire, rsp_take, ev_leaf_ok, ev_descend, ev_fault;

  assign flg = '{v: mem_rsp_data[BIT_V], r: mem_rsp_data[BIT_R], w: mem_rsp_data[BIT_W],
                 x: mem_rsp_data[BIT_X], a: mem_rsp_data[BIT_A], d: mem_rsp_data[BIT_D]};
  assign pte_ppn  = mem_rsp_data[PPN_LSB +: PPN_W];
  assign pte_rsvd = mem_rsp_data[PTE_W-1 -: RSVD_W];

  ptw_pte_eval #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .RSVD_W(RSVD_W), .LVL_W(LVL_W)
  ) u_eval (
    .flags(flg), .rsvd(pte_rsvd), .ppn(pte_ppn), .lvl(lvl), .acc(acc_q),
    .bad_enc(bad_enc), .is_leaf(is_leaf), .perm_ok(perm_ok), .ad_ok(ad_ok),
    .sp_aligned(sp_aligned), .dead_end(dead_end)
  );

  ptw_addr_gen #(
    .VA_W(VA_W), .PPN_W(PPN_W), .VPN_W(VPN_W), .PGOFF_W(PGOFF_W),
    .PTE_LG(PTE_LG), .LVL_W(LVL_W), .PA_W(PA_W)
  ) u_addr (
    .base_ppn(base_ppn), .leaf_ppn(pte_ppn), .va(va_q), .lvl(lvl),
    .pte_addr(mem_req_addr), .leaf_pa(leaf_pa)
  );

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_REQ);
  assign done          = (st == ST_DONE);
  assign done_fault    = fault_q;
  assign done_paddr    = pa_q;

  assign req_fire   = req_valid && req_ready;
  assign rsp_take   = (st == ST_WAIT) && mem_rsp_valid;
  assign ev_leaf_ok = rsp_take && !bad_enc && is_leaf && perm_ok && ad_ok && sp_aligned;
  assign ev_descend = rsp_take && !bad_enc && !is_leaf && !dead_end;
  assign ev_fault   = rsp_take && !ev_leaf_ok && !ev_descend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      lvl      <= '0;
      base_ppn <= '0;
      va_q     <= '0;
      acc_q    <= ACC_LOAD;
      fault_q  <= 1'b0;
      pa_q     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_fire) begin
          va_q     <= req_vaddr;
          acc_q    <= acc_e'(req_acc);
          base_ppn <= req_root;
          lvl      <= TOP_LVL;
          st       <= ST_REQ;
        end
        ST_REQ: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: begin
          if (ev_descend) begin
            lvl      <= lvl - 1'b1;
            base_ppn <= pte_ppn;
            st       <= ST_REQ;
          end else if (ev_leaf_ok) begin
            fault_q <= 1'b0;
            pa_q    <= leaf_pa;
            st      <= ST_DONE;
          end else if (ev_fault) begin
            fault_q <= 1'b1;
            pa_q    <= '0;
            st      <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vm_walker_chk.sv
module vm_walker_chk #(
  parameter int VA_W    = 48,
  parameter int PPN_W   = 44,
  parameter int VPN_W   = 9,
  parameter int PGOFF_W = 12,
  parameter int PTE_W   = 64,
  parameter int PTE_LG  = 3,
  parameter int PA_W    = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic [PPN_W-1:0] req_root,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic [PTE_W-1:0] mem_rsp_data,
  input logic             done,
  input logic             done_fault,
  input logic [PA_W-1:0]  done_paddr,
  input logic             ev_descend,
  input logic             ev_fault
);

  logic [VA_W-1:0]  va_c;
  logic [PPN_W-1:0] root_c;
  logic             first_c;
  logic [PA_W-1:0]  first_exp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_c    <= '0;
      root_c  <= '0;
      first_c <= 1'b0;
    end else if (req_valid && req_ready) begin
      va_c    <= req_vaddr;
      root_c  <= req_root;
      first_c <= 1'b1;
    end else if (mem_req_valid && mem_req_ready) begin
      first_c <= 1'b0;
    end
  end

  always_comb begin
    first_exp = '0;
    first_exp[PA_W-1:PGOFF_W] = root_c;
    first_exp[PTE_LG +: VPN_W] = va_c[VA_W-1 -: VPN_W];
  end

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  assert_done_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_not_ready_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  assert_first_read_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && first_c |-> mem_req_addr == first_exp);
  assert_descend_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_descend |=> mem_req_valid && !done);
  assert_fault_reports_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> done && done_fault);
  assert_fault_zero_pa_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault |-> done_paddr == '0);
  assert_page_offset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_fault |-> done_paddr[PGOFF_W-1:0] == va_c[PGOFF_W-1:0]);
  assert_read_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  assert_no_read_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);
  assert_rsp_known_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !$isunknown(mem_rsp_data));

endmodule

bind vm_walker vm_walker_chk #(
  .VA_W(VA_W), .PPN_W(PPN_W), .VPN_W(VPN_W), .PGOFF_W(PGOFF_W),
  .PTE_W(PTE_W), .PTE_LG(PTE_LG), .PA_W(PA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .req_root(req_root), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
  .done_fault(done_fault), .done_paddr(done_paddr), .ev_descend(ev_descend),
  .ev_fault(ev_fault)
);

// File: tb/vm_walker_tb.sv
`timescale 1ns/1ps
module vm_walker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic [43:0] req_root = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done;
  logic        done_fault;
  logic [55:0] done_paddr;

  always #2.5 clk = ~clk;

  vm_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
    .done_paddr(done_paddr)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [63:0] pt_mem [logic [55:0]];
  logic [55:0] exp_addr [4];
  int exp_n = 0;
  int rd_idx = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] vpn_of(input logic [47:0] va, input int l);
    return va[12 + 9*l +: 9];
  endfunction

  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [7:0] fl);
    return {10'b0, ppn, 2'b0, fl};
  endfunction

  function automatic logic [63:0] rd_mem(input logic [55:0] a);
    if (pt_mem.exists(a)) return pt_mem[a];
    return 64'd0;
  endfunction

  // reference walk written from the requirements
  task automatic ref_walk(input logic [47:0] va, input logic [43:0] root, input logic [1:0] acc,
                          output bit flt, output logic [55:0] pa, output string tag);
    logic [43:0] base;
    logic [63:0] pte;
    logic [55:0] a;
    bit need;
    base = root; flt = 1'b1; pa = '0; tag = "R6"; exp_n = 0;
    for (int l = 3; l >= 0; l--) begin
      a = {base, 12'h000} + {44'd0, vpn_of(va, l), 3'b000};
      exp_addr[exp_n] = a; exp_n++;
      pte = rd_mem(a);
      if (!pte[0]) begin tag = "R4"; return; end
      if ((pte[2] && !pte[1]) || pte[63:54] != 0) begin tag = "R5"; return; end
      if (pte[1] || pte[3]) begin
        case (acc)
          2'd0: need = pte[1];
          2'd1: need = pte[2];
          2'd2: need = pte[3];
          default: need = 1'b0;
        endcase
        if (!need) begin tag = "R7"; return; end
        if (!pte[6] || (acc == 2'd1 && !pte[7])) begin tag = "R8"; return; end
        for (int j = 0; j < l; j++)
          if (pte[10 + 9*j +: 9] != 0) begin tag = "R9"; return; end
        pa = {pte[53:10], va[11:0]};
        for (int j = 0; j < l; j++) pa[12 + 9*j +: 9] = va[12 + 9*j +: 9];
        flt = 1'b0; tag = "R10";
        return;
      end
      base = pte[53:10];
    end
  endtask

  // chain of pointers from the root down to leaf_lvl, where leaf_pte is placed
  task automatic build(input logic [47:0] va, input logic [43:0] root, input int leaf_lvl,
                       input logic [63:0] leaf_pte);
    logic [43:0] base;
    logic [43:0] nxt;
    logic [55:0] a;
    pt_mem.delete();
    base = root;
    for (int l = 3; l > leaf_lvl; l--) begin
      a = {base, 12'h000} + {44'd0, vpn_of(va, l), 3'b000};
      nxt = 44'h0000_0DE0_000 + 44'(l * 7 + 1);
      pt_mem[a] = mk_pte(nxt, 8'h01);
      base = nxt;
    end
    a = {base, 12'h000} + {44'd0, vpn_of(va, leaf_lvl), 3'b000};
    pt_mem[a] = leaf_pte;
  endtask

  // memory responder: random ready, 1 to 4 cycle latency
  initial begin
    int cnt;
    logic [63:0] held;
    cnt = 0; held = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = held; end
      end
      if (mem_req_valid)
        check(cnt == 0 && !mem_rsp_valid, "R12", "read issued with response pending",
              64'(cnt), 64'd0);
      mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && mem_req_ready && rst_n) begin
        if (rd_idx < exp_n)
          check(mem_req_addr == exp_addr[rd_idx], "R3", "entry address",
                64'(mem_req_addr), 64'(exp_addr[rd_idx]));
        else
          check(1'b0, "R3", "read beyond expected walk", 64'(rd_idx), 64'(exp_n));
        held = rd_mem(mem_req_addr);
        cnt = 1 + ($urandom % 4);
        rd_idx++;
      end
    end
  end

  task automatic run_walk(input logic [47:0] va, input logic [43:0] root, input logic [1:0] acc);
    bit eflt;
    logic [55:0] epa;
    string tag;
    int cyc;
    ref_walk(va, root, acc, eflt, epa, tag);
    rd_idx = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_root = root; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2", "ready low after acceptance", 64'(req_ready), 64'd0);
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    check(done, "R2", "done pulse seen", 64'(done), 64'd1);
    check(!req_ready, "R2", "ready low during done", 64'(req_ready), 64'd0);
    check(done_fault == eflt, tag, "fault flag", 64'(done_fault), 64'(eflt));
    check(done_paddr == epa, eflt ? "R11" : tag, "physical address", 64'(done_paddr), 64'(epa));
    check(rd_idx == exp_n, "R3", "read count", 64'(rd_idx), 64'(exp_n));
    @(negedge clk);
    check(!done && req_ready, "R2", "done one cycle then ready",
          64'({done, req_ready}), 64'b01);
  endtask

  localparam logic [47:0] VA_A = 48'hA5C3_1F2E_4D6B;
  localparam logic [43:0] ROOT = 44'h0000_0001_234;

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !done && !mem_req_valid, "R1", "reset state",
          64'({req_ready, done, mem_req_valid}), 64'b100);

    // 4 KiB leaves
    build(VA_A, ROOT, 0, mk_pte(44'h0AB_CDE1_2345, 8'h43)); run_walk(VA_A, ROOT, 2'd0); // R10
    build(VA_A, ROOT, 0, mk_pte(44'h0AB_CDE1_2345, 8'hC7)); run_walk(VA_A, ROOT, 2'd1); // R10
    // large pages, aligned
    build(VA_A, ROOT, 2, mk_pte(44'h123_4500_0000 & ~44'h3FFFF, 8'h43)); run_walk(VA_A, ROOT, 2'd0); // R10
    build(VA_A, ROOT, 3, mk_pte(44'hF80_0000_0000, 8'h4B)); run_walk(VA_A, ROOT, 2'd2); // R10
    build(VA_A, ROOT, 1, mk_pte(44'h000_0003_5E00, 8'h43)); run_walk(VA_A, ROOT, 2'd0); // R10
    // misaligned large pages R9
    build(VA_A, ROOT, 1, mk_pte(44'h000_0003_5E01, 8'h43)); run_walk(VA_A, ROOT, 2'd0);
    build(VA_A, ROOT, 3, mk_pte(44'hF80_0000_0000 | 44'h400_0000, 8'h43)); run_walk(VA_A, ROOT, 2'd0);
    // invalid R4
    build(VA_A, ROOT, 3, 64'd0); run_walk(VA_A, ROOT, 2'd0);
    build(VA_A, ROOT, 0, mk_pte(44'h55, 8'hCE)); run_walk(VA_A, ROOT, 2'd0);
    // reserved encodings R5
    build(VA_A, ROOT, 1, mk_pte(44'h0, 8'h45)); run_walk(VA_A, ROOT, 2'd1);
    build(VA_A, ROOT, 0, mk_pte(44'h77, 8'h4D)); run_walk(VA_A, ROOT, 2'd2);
    build(VA_A, ROOT, 0, mk_pte(44'h77, 8'h43) | (64'd1 << 60)); run_walk(VA_A, ROOT, 2'd0);
    // pointer at the bottom level R6
    build(VA_A, ROOT, 0, mk_pte(44'h99, 8'h01)); run_walk(VA_A, ROOT, 2'd0);
    // permissions R7
    build(VA_A, ROOT, 0, mk_pte(44'h321, 8'hC3)); run_walk(VA_A, ROOT, 2'd1);
    run_walk(VA_A, ROOT, 2'd2);
    run_walk(VA_A, ROOT, 2'd3);
    build(VA_A, ROOT, 0, mk_pte(44'h321, 8'h49)); run_walk(VA_A, ROOT, 2'd2);
    run_walk(VA_A, ROOT, 2'd0);
    // accessed / dirty R8
    build(VA_A, ROOT, 0, mk_pte(44'h321, 8'h83)); run_walk(VA_A, ROOT, 2'd0);
    build(VA_A, ROOT, 0, mk_pte(44'h321, 8'h47)); run_walk(VA_A, ROOT, 2'd1);
    run_walk(VA_A, ROOT, 2'd0);

    // constrained random walks
    for (int k = 0; k < 400; k++) begin
      logic [47:0] va;
      logic [43:0] root;
      logic [43:0] ppn;
      logic [7:0]  fl;
      logic [63:0] pte;
      int lv;
      va   = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      root = {$urandom, $urandom} & 44'hFFF_FFFF_FFFF;
      lv   = $urandom % 4;
      ppn  = {$urandom, $urandom} & 44'hFFF_FFFF_FFFF;
      if (($urandom % 3) != 0) ppn = ppn & ({44{1'b1}} << (9 * lv));
      fl = 8'($urandom);
      fl[0] = ($urandom % 10) != 0;
      fl[6] = ($urandom % 10) != 0;
      fl[7] = ($urandom % 5) != 0;
      if (($urandom % 6) == 0) begin fl[1] = 1'b0; fl[3] = 1'b0; end
      pte = mk_pte(ppn, fl);
      if (($urandom % 20) == 0) pte[54 + ($urandom % 10)] = 1'b1;
      build(va, root, lv, pte);
      run_walk(va, root, 2'($urandom % 4));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule